// File: doc/BRIEF.md
# Shadowed Gamma Channel Register Controller

This block is the storage back-end behind a byte-level serial slave in a multi-channel gamma reference generator. It keeps eight volatile channel registers whose committed copies drive the DAC code outputs. It also keeps a volatile control register with one mode bit, and it drives a byte-wide nonvolatile store that sits outside the block. After reset it copies every nonvolatile byte into its channel register. The copied codes reach the DAC outputs only when all eight have been loaded.

The serial slave hands the block decoded events: the memory-address byte of a write, each data byte, each read byte consumed, and STOP. While the mode bit is 0, channel writes are marked for nonvolatile programming. At STOP the marked bytes are programmed inside one timed busy window, and the slave refuses the bus for as long as that window lasts. While the mode bit is 1, only the volatile copy changes. In either mode the DAC codes take their new values at the STOP that closes the write.

Top module: `gamma_shadow_ctrl`

## Requirements
- R1: After reset `ready` is 0 and `busy` is 1 while channel i is read from nonvolatile address i. Once all channels are loaded, `ready` rises, `busy` falls, and each DAC code equals its nonvolatile byte. The store is preset to 80h.
- R2: Address 08h is the control register. It resets to 00h, and its bit 7 is the mode bit. Only bit 7 is stored, so reads of 08h return {mode, 7'b0}.
- R3: With mode 0, a data byte to a channel address (00h to 07h) updates the volatile register. That channel's nonvolatile byte is programmed with the same value after the next STOP.
- R4: With mode 1, a channel write updates only the volatile register. No nonvolatile write is issued, and no busy window follows its STOP.
- R5: Reads of 00h to 07h return the volatile register in either mode. Reads of 09h and above return 00h, and writes there change nothing.
- R6: Writing the mode bit, in either direction, leaves every volatile and nonvolatile byte unchanged.
- R7: The DAC codes change only on the clock edge that samples STOP (or at the end of the load in R1). Data bytes alone leave them unchanged.
- R8: A STOP that leaves bytes pending raises `busy` for exactly WR_CYCLES cycles. The pending channels are written one per cycle at the start of that window, lowest channel first. A STOP with nothing pending raises no busy window.
- R9: While `busy` is 1, address, data, read-advance and STOP strobes are ignored.
- R10: Each data byte advances the address counter within its 4-byte page: address bits [1:0] wrap and bits [7:2] hold. Each read advance increments the counter by one across page boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddrVld | input | 1 | Memory-address byte of a write transaction is valid |
| memAddr | input | ADDR_W | Memory-address byte, loaded into the address counter |
| wrVld | input | 1 | Data byte is valid |
| wrData | input | DATA_W | Data byte written at the address counter |
| rdAck | input | 1 | Read byte consumed; advance the address counter |
| stopVld | input | 1 | STOP seen; ends the transaction |
| rdData | output | DATA_W | Byte at the address counter |
| busy | output | 1 | Load or programming in progress; the slave must not acknowledge |
| ready | output | 1 | Power-up load complete |
| dacCode | output | NUM_CH*DATA_W | Committed DAC codes; channel i in bits [i*DATA_W +: DATA_W] |
| nvAddr | output | CH_W | Nonvolatile store byte address |
| nvRdEn | output | 1 | Nonvolatile read; data returns one cycle later |
| nvRdData | input | DATA_W | Nonvolatile read data |
| nvWrEn | output | 1 | Nonvolatile byte write |
| nvWrData | output | DATA_W | Nonvolatile write data |

## Verification
The bench sweeps write patterns across both pages in both modes. It keeps its own model of the volatile, nonvolatile and committed bytes, the mode bit and the pending set.

The corner cases it targets, and how a faulty design would show them:
- **DAC hold before STOP.** A design that updated the DAC on every byte would show new codes before the STOP.
- **Page wrap.** A design that carried into address bit 2 would write the next page.
- **Mode 1 writes.** A design that programmed these would change the bench's store or raise `busy`.
- **Strobes during the window.** A design that accepted them would overwrite channel 1 or lengthen the window.
- **Window length and order.** The bench counts the busy window's length and records the order of the nonvolatile writes.
- **Reload after a second reset.** This shows which bytes really reached nonvolatile storage.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  // Strobes from the control FSM to the datapath, one cycle each
  typedef struct packed {
    logic setAddr;  // load the address counter
    logic wrByte;   // store a data byte at the counter
    logic rdAdv;    // advance the counter after a read
    logic commit;   // copy the volatile registers to the DAC codes
    logic loadCap;  // capture nonvolatile read data into a channel
    logic progWr;   // one pending byte is being programmed
  } strobe_t;

  typedef enum logic [1:0] {ST_LOAD, ST_COMMIT, ST_IDLE, ST_BUSY} state_t;
endpackage

// File: rtl/gsc_ctrl.sv
module gsc_ctrl
  import gsc_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int WR_CYCLES = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memAddrVld,
  input  logic              wrVld,
  input  logic              rdAck,
  input  logic              stopVld,
  input  logic [NUM_CH-1:0] pendMask,
  output strobe_t           strb,
  output logic [CH_W-1:0]   chIdx,
  output logic [CH_W-1:0]   nvAddr,
  output logic              nvRdEn,
  output logic              nvWrEn,
  output logic              busy,
  output logic              ready
);
  localparam int LC_W = CH_W + 1;
  localparam int WC_W = $clog2(WR_CYCLES + 1);
  localparam int BL_W = $clog2(WR_CYCLES + NUM_CH + 4) + 1;

  state_t          state;
  logic [LC_W-1:0] loadCnt;
  logic            capValid;
  logic [CH_W-1:0] capIdx;
  logic [WC_W-1:0] waitCnt;
  logic [CH_W-1:0] progIdx;
  logic            anyPend;

  assign anyPend = |pendMask;

  // Lowest pending channel is programmed first
  always_comb begin
    progIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pendMask[i]) progIdx = CH_W'(i);
  end

  always_comb begin
    strb   = '0;
    nvRdEn = 1'b0;
    nvWrEn = 1'b0;
    unique case (state)
      ST_LOAD: begin
        nvRdEn       = (loadCnt < LC_W'(NUM_CH));
        strb.loadCap = capValid;
      end
      ST_COMMIT: strb.commit = 1'b1;
      ST_IDLE: begin
        strb.setAddr = memAddrVld;
        strb.wrByte  = wrVld;
        strb.rdAdv   = rdAck;
        strb.commit  = stopVld;
      end
      ST_BUSY: begin
        nvWrEn      = anyPend;
        strb.progWr = anyPend;
      end
      default: ;
    endcase
  end

  assign chIdx  = (state == ST_LOAD) ? capIdx : progIdx;
  assign nvAddr = (state == ST_LOAD) ? loadCnt[CH_W-1:0] : progIdx;
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_LOAD;
      loadCnt  <= '0;
      capValid <= 1'b0;
      capIdx   <= '0;
      waitCnt  <= '0;
      ready    <= 1'b0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          capValid <= (loadCnt < LC_W'(NUM_CH));
          capIdx   <= loadCnt[CH_W-1:0];
          if (loadCnt < LC_W'(NUM_CH)) loadCnt <= loadCnt + 1'b1;
          else state <= ST_COMMIT;
        end
        ST_COMMIT: begin
          ready <= 1'b1;
          state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (stopVld && anyPend) begin
            state   <= ST_BUSY;
            waitCnt <= '0;
          end
        end
        ST_BUSY: begin
          if (waitCnt == WC_W'(WR_CYCLES - 1) && !anyPend) state <= ST_IDLE;
          else if (waitCnt != WC_W'(WR_CYCLES - 1)) waitCnt <= waitCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Run length of busy, used by the window check below
  logic [BL_W-1:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else busyLen <= busy ? busyLen + 1'b1 : '0;
  end

  // R1
  load_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> busy);
  // R8
  nv_wr_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    nvWrEn |-> (busy && ready));
  // R8
  prog_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nvWrEn && $past(nvWrEn)) |-> (nvAddr > $past(nvAddr)));
  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(ready)) |-> (busyLen == BL_W'(WR_CYCLES)));
endmodule

// File: rtl/gsc_datapath.sv
module gsc_datapath
  import gsc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int PAGE   = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PAGE_W = $clog2(PAGE)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [CH_W-1:0]          chIdx,
  input  logic [ADDR_W-1:0]        memAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [DATA_W-1:0]        nvRdData,
  output logic [DATA_W-1:0]        rdData,
  output logic [DATA_W-1:0]        nvWrData,
  output logic [NUM_CH-1:0]        pendMask,
  output logic [NUM_CH*DATA_W-1:0] dacCode
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  logic [ADDR_W-1:0] addrCnt, pageNext;
  logic [DATA_W-1:0] chan [NUM_CH];
  logic [DATA_W-1:0] dac  [NUM_CH];
  logic              mode;
  logic              inChan, isCtrl;
  logic [CH_W-1:0]   aIdx;

  assign inChan = (addrCnt < CTRL_ADDR);
  assign isCtrl = (addrCnt == CTRL_ADDR);
  assign aIdx   = addrCnt[CH_W-1:0];

  // Data bytes wrap inside the current page
  always_comb begin
    pageNext = addrCnt;
    pageNext[PAGE_W-1:0] = addrCnt[PAGE_W-1:0] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt  <= '0;
      mode     <= 1'b0;
      pendMask <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        chan[i] <= '0;
        dac[i]  <= '0;
      end
    end else begin
      if (strb.setAddr)     addrCnt <= memAddr;
      else if (strb.wrByte) addrCnt <= pageNext;
      else if (strb.rdAdv)  addrCnt <= addrCnt + 1'b1;

      if (strb.wrByte && inChan) begin
        chan[aIdx] <= wrData;
        if (!mode) pendMask[aIdx] <= 1'b1;
      end
      if (strb.wrByte && isCtrl) mode <= wrData[DATA_W-1];
      if (strb.loadCap) chan[chIdx] <= nvRdData;
      if (strb.progWr)  pendMask[chIdx] <= 1'b0;
      if (strb.commit)
        for (int i = 0; i < NUM_CH; i++) dac[i] <= chan[i];
    end
  end

  always_comb begin
    if (inChan)      rdData = chan[aIdx];
    else if (isCtrl) rdData = {mode, {(DATA_W-1){1'b0}}};
    else             rdData = '0;
  end

  assign nvWrData = chan[chIdx];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dac
    assign dacCode[g*DATA_W +: DATA_W] = dac[g];
  end

  // R7
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(dacCode));
  // R4
  mode1_nopend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrByte && mode) |=> (pendMask == $past(pendMask)));
endmodule

// File: rtl/gamma_shadow_ctrl.sv
module gamma_shadow_ctrl
  import gsc_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int PAGE      = 4,
  parameter int WR_CYCLES = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     memAddrVld,
  input  logic [ADDR_W-1:0]        memAddr,
  input  logic                     wrVld,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     rdAck,
  input  logic                     stopVld,
  output logic [DATA_W-1:0]        rdData,
  output logic                     busy,
  output logic                     ready,
  output logic [NUM_CH*DATA_W-1:0] dacCode,
  output logic [CH_W-1:0]          nvAddr,
  output logic                     nvRdEn,
  input  logic [DATA_W-1:0]        nvRdData,
  output logic                     nvWrEn,
  output logic [DATA_W-1:0]        nvWrData
);
  strobe_t           strb;
  logic [CH_W-1:0]   chIdx;
  logic [NUM_CH-1:0] pendMask;

  gsc_ctrl #(.NUM_CH(NUM_CH), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk, .rstN, .memAddrVld, .wrVld, .rdAck, .stopVld, .pendMask,
    .strb, .chIdx, .nvAddr, .nvRdEn, .nvWrEn, .busy, .ready
  );

  gsc_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE(PAGE)) u_dp (
    .clk, .rstN, .strb, .chIdx, .memAddr, .wrData, .nvRdData,
    .rdData, .nvWrData, .pendMask, .dacCode
  );
endmodule

// File: tb/gamma_shadow_ctrl_test.sv
module gamma_shadow_ctrl_test;
  localparam int NCH = 8;
  localparam int WRC = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, memAddrVld, wrVld, rdAck, stopVld;
  logic [7:0] memAddr, wrData, rdData, nvRdData, nvWrData;
  logic busy, ready, nvRdEn, nvWrEn;
  logic [2:0] nvAddr;
  logic [NCH*8-1:0] dacCode;

  gamma_shadow_ctrl #(.WR_CYCLES(WRC)) uut (
    .clk, .rstN, .memAddrVld, .memAddr, .wrVld, .wrData, .rdAck, .stopVld,
    .rdData, .busy, .ready, .dacCode, .nvAddr, .nvRdEn, .nvRdData,
    .nvWrEn, .nvWrData
  );

  // Nonvolatile store model with one-cycle read latency
  logic [7:0] nvMem [NCH];
  logic factory, logClr;
  int wrLogCnt;
  logic [2:0] wrLog [16];
  always @(posedge clk) begin
    if (factory) for (int i = 0; i < NCH; i++) nvMem[i] <= 8'h80;
    else if (nvWrEn) nvMem[nvAddr] <= nvWrData;
    if (nvRdEn) nvRdData <= nvMem[nvAddr];
    if (logClr) wrLogCnt <= 0;
    else if (nvWrEn && wrLogCnt < 16) begin
      wrLog[wrLogCnt] <= nvAddr;
      wrLogCnt <= wrLogCnt + 1;
    end
  end

  int tests = 0, fails = 0;
  logic [7:0] expChan [NCH];
  logic [7:0] expNv   [NCH];
  logic [7:0] expDac  [NCH];
  logic [NCH-1:0] expPend;
  logic expMode;
  logic [7:0] curA;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pA(input logic [7:0] a);
    memAddr = a; memAddrVld = 1'b1; @(negedge clk); memAddrVld = 1'b0;
  endtask
  task automatic pW(input logic [7:0] d);
    wrData = d; wrVld = 1'b1; @(negedge clk); wrVld = 1'b0;
  endtask
  task automatic pS();
    stopVld = 1'b1; @(negedge clk); stopVld = 1'b0;
  endtask
  task automatic pR(output logic [7:0] d);
    d = rdData; rdAck = 1'b1; @(negedge clk); rdAck = 1'b0;
  endtask

  // Data byte with bench-side model update
  task automatic mW(input logic [7:0] d);
    if (curA < 8) begin
      expChan[curA[2:0]] = d;
      if (!expMode) begin expNv[curA[2:0]] = d; expPend[curA[2:0]] = 1'b1; end
    end else if (curA == 8'h08) expMode = d[7];
    pW(d);
    curA = {curA[7:2], curA[1:0] + 2'd1};
  endtask

  task automatic checkDac(input string tag);
    for (int i = 0; i < NCH; i++) chk(tag, dacCode[i*8 +: 8], expDac[i]);
  endtask
  task automatic checkNv(input string tag);
    for (int i = 0; i < NCH; i++) chk(tag, nvMem[i], expNv[i]);
  endtask
  task automatic checkReads(input string tag);
    logic [7:0] d;
    pA(8'h00);
    for (int i = 0; i < NCH; i++) begin pR(d); chk(tag, d, expChan[i]); end
  endtask

  // One write transaction of n bytes, value base + step*k
  task automatic txn(input logic [7:0] start, input int n, input logic [7:0] base,
                     input logic [7:0] step, input string tag);
    int len, j;
    logic [NCH-1:0] pendSnap;
    logClr = 1'b1; @(negedge clk); logClr = 1'b0;
    expPend = '0;
    curA = start; pA(start);
    for (int k = 0; k < n; k++) mW(base + step * 8'(k));
    checkDac("R7 dac held before STOP");
    pendSnap = expPend;
    pS();
    for (int i = 0; i < NCH; i++) expDac[i] = expChan[i];
    checkDac("R7 dac after STOP");
    len = 0;
    while (busy && len < 1000) begin len++; @(negedge clk); end
    chk("R8 busy window length", len, (pendSnap != 0) ? WRC : 0);
    chk("R8 nv write count", wrLogCnt, $countones(pendSnap));
    j = 0;
    for (int i = 0; i < NCH; i++)
      if (pendSnap[i]) begin chk("R8 program order", wrLog[j], i); j++; end
    checkNv(tag);
  endtask

  initial begin
    logic [7:0] d;
    int len;
    rstN = 1'b0; factory = 1'b1; logClr = 1'b1;
    memAddrVld = 0; wrVld = 0; rdAck = 0; stopVld = 0; memAddr = 0; wrData = 0;
    expMode = 1'b0; expPend = '0; curA = 0;
    for (int i = 0; i < NCH; i++) begin expChan[i] = 8'h80; expNv[i] = 8'h80; expDac[i] = 8'h80; end
    repeat (3) @(negedge clk);
    factory = 1'b0; logClr = 1'b0; rstN = 1'b1;
    chk("R1 ready low after reset", ready, 0);
    chk("R1 busy during load", busy, 1);
    len = 0;
    while (!ready && len < 100) begin len++; @(negedge clk); end
    chk("R1 busy clear after load", busy, 0);
    checkDac("R1 dac from factory bytes");
    pA(8'h08); pR(d); chk("R2 control reset value", d, 8'h00);

    // Mode 0 sweep over both pages
    for (int p = 0; p < 2; p++)
      txn(8'(p * 4), 4, 8'(p * 148 + 5), 8'd37, "R3 nv copy mode 0");
    checkReads("R5 readback mode 0");

    // Strobes during the busy window are ignored
    curA = 8'h00; expPend = '0; pA(8'h00); mW(8'h3C); pS();
    for (int i = 0; i < NCH; i++) expDac[i] = expChan[i];
    chk("R9 window open", busy, 1);
    pA(8'h01); pW(8'hFF); pS(); rdAck = 1'b1; @(negedge clk); rdAck = 1'b0;
    while (busy) @(negedge clk);
    checkReads("R9 write during busy ignored");
    checkDac("R9 stop during busy ignored");
    checkNv("R9 nv untouched by ignored write");

    // Page wrap: 06h, 07h, then 04h
    txn(8'h06, 3, 8'hA1, 8'h11, "R10 page wrap nv");
    checkReads("R10 page wrap readback");

    // Mode 1: volatile only
    txn(8'h08, 1, 8'h80, 8'h00, "R6 mode set keeps nv");
    pA(8'h08); pR(d); chk("R2 mode bit reads back", d, 8'h80);
    for (int p = 0; p < 2; p++)
      txn(8'(p * 4), 4, 8'(p * 77 + 9), 8'd91, "R4 nv unchanged mode 1");
    checkReads("R5 readback mode 1 volatile");

    // Mode back to 0 with reserved bits set
    txn(8'h08, 1, 8'h7F, 8'h00, "R6 mode clear keeps nv");
    pA(8'h08); pR(d); chk("R2 reserved bits read zero", d, 8'h00);
    checkReads("R6 volatile unchanged by mode change");

    // Reserved addresses
    txn(8'h09, 2, 8'h55, 8'h11, "R5 reserved write no nv");
    pA(8'h09); pR(d); chk("R5 reserved read 09h", d, 0);
    pR(d); chk("R5 reserved read 0Ah", d, 0);
    checkReads("R5 reserved write no effect");

    // Read advance crosses the page boundary
    pA(8'h03);
    for (int i = 3; i < 6; i++) begin pR(d); chk("R10 linear read advance", d, expChan[i]); end

    // Second reset reloads what reached nonvolatile storage
    rstN = 1'b0; repeat (2) @(negedge clk); rstN = 1'b1;
    chk("R1 ready low after second reset", ready, 0);
    len = 0;
    while (!ready && len < 100) begin len++; @(negedge clk); end
    for (int i = 0; i < NCH; i++) begin expChan[i] = expNv[i]; expDac[i] = expNv[i]; end
    checkDac("R1 dac reloaded from nv");
    checkReads("R1 volatile reloaded from nv");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule